// File: doc/BRIEF.md
# Paired-Page Variable-Size TLB Lookup

This block is a fully associative translation buffer of 48 entries. Each entry describes a pair of neighbouring virtual pages, even and odd, that share one tag. The page size belongs to the entry: a 3-bit size code picks a page of 4 KB, 16 KB, 64 KB and so on up to 64 MB. Each entry also carries an address-space tag and a global flag that makes it match in every address space. A lookup presents a 32-bit virtual address, the current address-space tag and a read/write flag. One cycle later the block returns an access grade (fail, read-only or read/write), a 32-bit physical address and a fault code, together with a flag that tells a refill miss apart from the other faults.

Entries are loaded through an index-addressed write port. One write carries the size code, the tag word (upper virtual page-pair number, address-space tag, global flag) and the two page descriptors (frame number, valid, dirty). The request side is run by a two-state machine. ST_IDLE goes to ST_RESP when `lk_req` is high. ST_RESP stays in ST_RESP while requests keep coming and returns to ST_IDLE when `lk_req` is low. `rsp_valid` is high exactly while the machine is in ST_RESP.

Top module: `ptlb_lookup`

## Requirements
- R1: A write with `wr_en` high replaces entry `wr_idx` at the next rising clock edge. A lookup issued in the same cycle as the write sees the old contents, and a lookup issued in a later cycle sees the new ones.
- R2: A lookup is issued by holding `lk_req` high for one cycle, and its result is presented with `rsp_valid` high in the following cycle. Lookups may be issued in back-to-back cycles. `rsp_valid` is low in a cycle that follows a cycle without `lk_req`.
- R3: A size code c (0..7) gives the page shift s = 12 + 2c. The stored tag field `wr_vpn2` holds virtual address bits [31:13]. Only the address bits at positions s+1 and above are compared, so stored tag bits below that position are ignored.
- R4: Virtual address bit s selects the page of the pair: 0 selects the even descriptor (`*0`), 1 selects the odd descriptor (`*1`).
- R5: An entry matches only when its address-space tag equals `lk_asid` or its global flag is set.
- R6: When several entries match, the one with the lowest index decides the result, even when its selected page is invalid.
- R7: On a successful translation, `rsp_pa` equals the frame number shifted left by 12, ORed with the virtual address bits below s.
- R8: A successful translation gives `rsp_hit` = 2 (read/write) when the selected page is dirty and `rsp_hit` = 1 (read-only) when it is clean. A read of a clean page succeeds, and `rsp_exc` is then 0.
- R9: A match whose selected page has its valid bit clear gives `rsp_hit` = 0 and `rsp_refill` = 0. `rsp_exc` is then 2 for a read or 3 for a write.
- R10: A write that matches a valid, clean page gives `rsp_hit` = 0, `rsp_exc` = 1 and `rsp_refill` = 0.
- R11: When no entry matches, the result is `rsp_hit` = 0 and `rsp_refill` = 1. `rsp_exc` is then 2 for a read or 3 for a write.
- R12: Reset clears every field of every entry and leaves `rsp_valid` low. A read of address 0 with address-space tag 0 right after reset therefore matches entry 0 on an invalid page.
- On every fault, `rsp_pa` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Load an entry this cycle |
| wr_idx | input | 6 | Index of the entry to load |
| wr_sz | input | 3 | Page size code c; the page shift is 12+2c |
| wr_vpn2 | input | 19 | Tag of the page pair (virtual address bits [31:13]) |
| wr_asid | input | 8 | Address-space tag of the entry |
| wr_g | input | 1 | Global flag: the entry matches in every address space |
| wr_pfn0 | input | 20 | Frame number of the even page |
| wr_v0 | input | 1 | Even page valid |
| wr_d0 | input | 1 | Even page dirty (writable) |
| wr_pfn1 | input | 20 | Frame number of the odd page |
| wr_v1 | input | 1 | Odd page valid |
| wr_d1 | input | 1 | Odd page dirty (writable) |
| lk_req | input | 1 | Issue a lookup this cycle |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space tag |
| lk_wr | input | 1 | 1 for a store access, 0 for a load access |
| rsp_valid | output | 1 | Result of the previous cycle's lookup is present |
| rsp_hit | output | 2 | 0 fail, 1 read-only, 2 read/write |
| rsp_pa | output | 32 | Physical address, 0 on a fault |
| rsp_exc | output | 2 | 0 none, 1 modify, 2 load fault, 3 store fault |
| rsp_refill | output | 1 | The fault is a refill (no entry matched) |

## Verification
The bench goes after the boundaries of the variable compare width. It stores an entry whose tag has junk below its compare position, and it probes an address that differs just one bit above that position. A design that compared a fixed width would report the first case as a miss and the second as a hit. It checks both halves of pairs at the 4 KB, 64 KB and 64 MB sizes, where a misplaced select bit or offset mask gives a wrong physical address or a wrong read-only/read-write grade. It sets up two overlapping matches, one of them made invalid afterwards, and issues a lookup in the same cycle as a write. A wrong priority order returns the higher entry's frame, and a write-through path shows the new contents one cycle early.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
    parameter int VA_W       = 32;
    parameter int ASID_W     = 8;
    parameter int PFN_W      = 20;
    parameter int SZ_W       = 3;
    parameter int BASE_SHIFT = 12;

    localparam int VPN2_W = VA_W - BASE_SHIFT - 1;
    localparam int PA_W   = PFN_W + BASE_SHIFT;
    localparam int SH_W   = $clog2(VA_W);

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             v;
        logic             d;
    } half_t;

    typedef struct packed {
        logic [SZ_W-1:0]   sz;
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic              g;
        half_t             lo0;
        half_t             lo1;
    } entry_t;

    typedef enum logic [1:0] {
        HIT_FAIL = 2'd0,
        HIT_RO   = 2'd1,
        HIT_RW   = 2'd2
    } hit_e;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_MOD  = 2'd1,
        EXC_TLBL = 2'd2,
        EXC_TLBS = 2'd3
    } exc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } st_e;
endpackage

// File: rtl/ptlb_entry_cmp.sv
module ptlb_entry_cmp
    import ptlb_pkg::*;
(
    input  entry_t            ent,
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] asid,
    output logic              match,
    output half_t             sel_half,
    output logic [VA_W-1:0]   off_mask
);
    logic [SH_W-1:0]   shamt;
    logic [VPN2_W-1:0] ign_mask;
    logic [VPN2_W-1:0] va_vpn2;
    logic              tag_eq;
    logic              space_ok;
    logic              odd;

    always_comb begin
        // page shift = base + 2 * size code (R3)
        shamt    = SH_W'(BASE_SHIFT) + SH_W'({ent.sz, 1'b0});
        ign_mask = (VPN2_W'(1) << {ent.sz, 1'b0}) - VPN2_W'(1);
        va_vpn2  = va[VA_W-1:BASE_SHIFT+1];
        tag_eq   = (((ent.vpn2 ^ va_vpn2) & ~ign_mask) == '0);
        space_ok = ent.g || (ent.asid == asid);          // R5
        match    = tag_eq && space_ok;
        odd      = va[shamt];                            // R4
        sel_half = odd ? ent.lo1 : ent.lo0;
        off_mask = (VA_W'(1) << shamt) - VA_W'(1);
    end
endmodule

// File: rtl/ptlb_prio.sv
module ptlb_prio #(
    parameter int N     = 48,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        // scan downward so the lowest set index is the last one kept (R6)
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
        any = |req;
        gnt = any ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/ptlb_resolve.sv
module ptlb_resolve
    import ptlb_pkg::*;
(
    input  logic            any_hit,
    input  half_t           half,
    input  logic [VA_W-1:0] off_mask,
    input  logic [VA_W-1:0] va,
    input  logic            is_wr,
    output hit_e            hit,
    output logic [PA_W-1:0] pa,
    output exc_e            exc,
    output logic            refill
);
    exc_e dir_code;

    always_comb begin
        dir_code = is_wr ? EXC_TLBS : EXC_TLBL;
        hit      = HIT_FAIL;
        pa       = '0;
        exc      = EXC_NONE;
        refill   = 1'b0;
        if (!any_hit) begin
            exc    = dir_code;                      // R11
            refill = 1'b1;
        end else if (!half.v) begin
            exc    = dir_code;                      // R9
        end else if (is_wr && !half.d) begin
            exc    = EXC_MOD;                       // R10
        end else begin
            hit    = half.d ? HIT_RW : HIT_RO;      // R8
            pa     = {half.pfn, {BASE_SHIFT{1'b0}}} | PA_W'(va & off_mask); // R7
        end
    end
endmodule

// File: rtl/ptlb_lookup.sv
module ptlb_lookup
    import ptlb_pkg::*;
#(
    parameter int N_ENT = 48,
    parameter int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SZ_W-1:0]   wr_sz,
    input  logic [VPN2_W-1:0] wr_vpn2,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_g,
    input  logic [PFN_W-1:0]  wr_pfn0,
    input  logic              wr_v0,
    input  logic              wr_d0,
    input  logic [PFN_W-1:0]  wr_pfn1,
    input  logic              wr_v1,
    input  logic              wr_d1,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_wr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_hit,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [1:0]        rsp_exc,
    output logic              rsp_refill
);
    entry_t            tbl [N_ENT];
    entry_t            new_ent;
    logic [N_ENT-1:0]  match_vec;
    logic [N_ENT-1:0]  gnt;
    half_t             half_vec [N_ENT];
    logic [VA_W-1:0]   mask_vec [N_ENT];
    logic              any_hit;
    logic [IDX_W-1:0]  win_idx;
    half_t             win_half;
    logic [VA_W-1:0]   win_mask;
    hit_e              res_hit;
    logic [PA_W-1:0]   res_pa;
    exc_e              res_exc;
    logic              res_refill;
    st_e               state_q, state_d;

    // ---------------- entry storage (R1, R12) ----------------
    always_comb begin
        new_ent.sz      = wr_sz;
        new_ent.vpn2    = wr_vpn2;
        new_ent.asid    = wr_asid;
        new_ent.g       = wr_g;
        new_ent.lo0.pfn = wr_pfn0;
        new_ent.lo0.v   = wr_v0;
        new_ent.lo0.d   = wr_d0;
        new_ent.lo1.pfn = wr_pfn1;
        new_ent.lo1.v   = wr_v1;
        new_ent.lo1.d   = wr_d1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) begin
                tbl[i] <= '0;
            end
        end else if (wr_en && (32'(wr_idx) < N_ENT)) begin
            tbl[wr_idx] <= new_ent;
        end
    end

    // ---------------- per-entry compare ----------------
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        ptlb_entry_cmp u_cmp (
            .ent      (tbl[g]),
            .va       (lk_va),
            .asid     (lk_asid),
            .match    (match_vec[g]),
            .sel_half (half_vec[g]),
            .off_mask (mask_vec[g])
        );
    end

    ptlb_prio #(.N(N_ENT), .IDX_W(IDX_W)) u_prio (
        .req (match_vec),
        .gnt (gnt),
        .any (any_hit),
        .idx (win_idx)
    );

    assign win_half = half_vec[win_idx];
    assign win_mask = mask_vec[win_idx];

    ptlb_resolve u_res (
        .any_hit  (any_hit),
        .half     (win_half),
        .off_mask (win_mask),
        .va       (lk_va),
        .is_wr    (lk_wr),
        .hit      (res_hit),
        .pa       (res_pa),
        .exc      (res_exc),
        .refill   (res_refill)
    );

    // ---------------- request state machine (R2) ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = lk_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = lk_req ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_hit    <= HIT_FAIL;
            rsp_pa     <= '0;
            rsp_exc    <= EXC_NONE;
            rsp_refill <= 1'b0;
        end else if (lk_req) begin
            rsp_hit    <= res_hit;
            rsp_pa     <= res_pa;
            rsp_exc    <= res_exc;
            rsp_refill <= res_refill;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

    // ---------------- assertions ----------------
    p_resp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    p_quiet_after_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    p_single_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_winner_is_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> ((match_vec & (gnt - N_ENT'(1))) == '0) && ((gnt & match_vec) != '0));

    p_refill_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_refill) |->
            (rsp_hit == HIT_FAIL) && (rsp_exc == ($past(lk_wr) ? EXC_TLBS : EXC_TLBL)));

    p_modify_on_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc == EXC_MOD) |-> $past(lk_wr) && !rsp_refill);

    p_clean_only_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit == HIT_RO) |-> !$past(lk_wr));

    p_pa_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit != HIT_FAIL) |->
            (rsp_pa[BASE_SHIFT-1:0] == $past(lk_va[BASE_SHIFT-1:0])) && (rsp_exc == EXC_NONE));
endmodule

// File: tb/tb_ptlb_lookup.sv
module tb_ptlb_lookup;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [2:0]  wr_sz = '0;
    logic [18:0] wr_vpn2 = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_g = 1'b0;
    logic [19:0] wr_pfn0 = '0;
    logic        wr_v0 = 1'b0;
    logic        wr_d0 = 1'b0;
    logic [19:0] wr_pfn1 = '0;
    logic        wr_v1 = 1'b0;
    logic        wr_d1 = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_wr = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_hit;
    logic [31:0] rsp_pa;
    logic [1:0]  rsp_exc;
    logic        rsp_refill;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ptlb_lookup dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_sz(wr_sz), .wr_vpn2(wr_vpn2),
        .wr_asid(wr_asid), .wr_g(wr_g),
        .wr_pfn0(wr_pfn0), .wr_v0(wr_v0), .wr_d0(wr_d0),
        .wr_pfn1(wr_pfn1), .wr_v1(wr_v1), .wr_d1(wr_d1),
        .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid), .lk_wr(lk_wr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
        .rsp_exc(rsp_exc), .rsp_refill(rsp_refill)
    );

    // {va, asid, wr, exp_hit, exp_pa, exp_exc, exp_refill, requirement number}
    localparam logic [81:0] VEC [16] = '{
        {32'h0040_0123, 8'd5, 1'b0, 2'd2, 32'h1234_5123, 2'd0, 1'b0, 4'd7},  // R7 even page
        {32'h0040_1FFF, 8'd5, 1'b0, 2'd1, 32'h00AB_CFFF, 2'd0, 1'b0, 4'd4},  // R4 odd, clean read
        {32'h0040_1004, 8'd5, 1'b1, 2'd0, 32'h0000_0000, 2'd1, 1'b0, 4'd10}, // R10 store to clean
        {32'h0040_0008, 8'd5, 1'b1, 2'd2, 32'h1234_5008, 2'd0, 1'b0, 4'd8},  // R8 store to dirty
        {32'h0040_0010, 8'd6, 1'b0, 2'd0, 32'h0000_0000, 2'd2, 1'b1, 4'd5},  // R5 tag mismatch
        {32'h1000_ABCD, 8'd3, 1'b0, 2'd2, 32'h4000_ABCD, 2'd0, 1'b0, 4'd5},  // R5 global entry
        {32'h1001_2345, 8'd3, 1'b1, 2'd0, 32'h0000_0000, 2'd3, 1'b0, 4'd9},  // R9 invalid store
        {32'h1001_0000, 8'd3, 1'b0, 2'd0, 32'h0000_0000, 2'd2, 1'b0, 4'd9},  // R9 invalid load
        {32'h1002_0000, 8'd3, 1'b0, 2'd0, 32'h0000_0000, 2'd2, 1'b1, 4'd3},  // R3 bit above compare
        {32'h1000_F000, 8'd3, 1'b0, 2'd2, 32'h4000_F000, 2'd0, 1'b0, 4'd3},  // R3 ignored tag bits
        {32'h8123_4567, 8'd1, 1'b0, 2'd1, 32'h0133_4567, 2'd0, 1'b0, 4'd3},  // R3 64 MB page
        {32'h8400_0010, 8'd1, 1'b1, 2'd2, 32'h0020_0010, 2'd0, 1'b0, 4'd4},  // R4 64 MB odd
        {32'h8000_0000, 8'd1, 1'b1, 2'd0, 32'h0000_0000, 2'd1, 1'b0, 4'd10}, // R10 large clean
        {32'h2000_0044, 8'd7, 1'b0, 2'd2, 32'h1111_1044, 2'd0, 1'b0, 4'd6},  // R6 lower wins
        {32'h2000_0044, 8'd8, 1'b0, 2'd2, 32'h2222_2044, 2'd0, 1'b0, 4'd6},  // R6 only global
        {32'h3000_0000, 8'd1, 1'b1, 2'd0, 32'h0000_0000, 2'd3, 1'b1, 4'd11}  // R11 store miss
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_rsp(input string req, input logic [1:0] hit, input logic [31:0] pa,
                             input logic [1:0] exc, input logic refill);
        check(req, "rsp_valid",  32'(rsp_valid), 32'd1);
        check(req, "rsp_hit",    32'(rsp_hit), 32'(hit));
        check(req, "rsp_pa",     rsp_pa, pa);
        check(req, "rsp_exc",    32'(rsp_exc), 32'(exc));
        check(req, "rsp_refill", 32'(rsp_refill), 32'(refill));
    endtask

    // called at a falling edge; leaves lk_req high for back-to-back use
    task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic wr);
        lk_req  = 1'b1;
        lk_va   = va;
        lk_asid = asid;
        lk_wr   = wr;
        @(negedge clk);
    endtask

    task automatic load(input logic [5:0] idx, input logic [2:0] sz, input logic [18:0] vpn2,
                        input logic [7:0] asid, input logic g,
                        input logic [19:0] p0, input logic v0, input logic d0,
                        input logic [19:0] p1, input logic v1, input logic d1);
        wr_en = 1'b1; wr_idx = idx; wr_sz = sz; wr_vpn2 = vpn2; wr_asid = asid; wr_g = g;
        wr_pfn0 = p0; wr_v0 = v0; wr_d0 = d0; wr_pfn1 = p1; wr_v1 = v1; wr_d1 = d1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "rsp_valid after reset", 32'(rsp_valid), 32'd0);

        // R12: cleared entry 0 matches va 0 / tag 0 with an invalid page
        lookup(32'h0, 8'd0, 1'b0);
        check_rsp("R12", 2'd0, 32'h0, 2'd2, 1'b0);
        lk_req = 1'b0;
        @(negedge clk);
        check("R2", "rsp_valid idle", 32'(rsp_valid), 32'd0);

        // entries
        load(6'd0,  3'd0, 19'h00200, 8'd5, 1'b0, 20'h12345, 1'b1, 1'b1, 20'h00ABC, 1'b1, 1'b0);
        load(6'd1,  3'd2, 19'h08005, 8'd9, 1'b1, 20'h40000, 1'b1, 1'b1, 20'h50000, 1'b0, 1'b0);
        load(6'd2,  3'd7, 19'h41234, 8'd1, 1'b0, 20'h00100, 1'b1, 1'b0, 20'h00200, 1'b1, 1'b1);
        load(6'd3,  3'd0, 19'h10000, 8'd7, 1'b0, 20'h11111, 1'b1, 1'b1, 20'h0,     1'b0, 1'b0);
        load(6'd10, 3'd0, 19'h10000, 8'd2, 1'b1, 20'h22222, 1'b1, 1'b1, 20'h0,     1'b0, 1'b0);

        // table walk, back-to-back lookups (R2)
        for (int k = 0; k < 16; k++) begin
            logic [81:0] v;
            string tag;
            v = VEC[k];
            tag = $sformatf("R%0d vec%0d", v[3:0], k);
            lookup(v[81:50], v[49:42], v[41]);
            check_rsp(tag, v[40:39], v[38:7], v[6:5], v[4]);
        end
        lk_req = 1'b0;
        @(negedge clk);
        check("R2", "rsp_valid drops", 32'(rsp_valid), 32'd0);

        // R1: write entry 3 (even page invalid, new frame) and look up in the same cycle
        wr_en = 1'b1; wr_idx = 6'd3; wr_sz = 3'd0; wr_vpn2 = 19'h10000; wr_asid = 8'd7;
        wr_g = 1'b0; wr_pfn0 = 20'h33333; wr_v0 = 1'b0; wr_d0 = 1'b1;
        wr_pfn1 = 20'h0; wr_v1 = 1'b0; wr_d1 = 1'b0;
        lookup(32'h2000_0044, 8'd7, 1'b0);
        wr_en = 1'b0;
        check_rsp("R1 same-cycle old", 2'd2, 32'h1111_1044, 2'd0, 1'b0);
        // R6: lowest-index match decides even though its page is invalid
        lookup(32'h2000_0044, 8'd7, 1'b0);
        check_rsp("R6 invalid low entry", 2'd0, 32'h0, 2'd2, 1'b0);
        // R1: make it valid again; next lookup sees the new frame
        lk_req = 1'b0;
        load(6'd3, 3'd0, 19'h10000, 8'd7, 1'b0, 20'h33333, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0);
        lookup(32'h2000_0044, 8'd7, 1'b0);
        check_rsp("R1 new contents", 2'd1, 32'h3333_3044, 2'd0, 1'b0);
        lk_req = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule